// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block supervises two reference clocks and chooses which of them should feed the downstream clock path. A fast system clock samples both references, a feedback clock and three control levels through two-flop synchronizers. A reference that shows no transition while the feedback clock makes two rising edges is stuck, high or low, for at least a full feedback period. It is then marked bad with a sticky per-input flag.

If the reference in use goes bad while the other one is healthy, the block moves the registered selection to the other input. It also raises a one-cycle notification pulse for downstream alignment logic. A manual override turns the automatic switching off, and the selection then tracks the requested input. An active-low alarm clear wipes both flags and puts the selection back on the requested input. The selection is a registered level for a clock multiplexer elsewhere. The block does not switch clocks itself.

Every asynchronous input passes through the synchronizer, so each output reacts to a level change on an input no earlier than the third rising edge of `clk` after it. `rst_n` is asynchronous on assertion and is expected to be released in step with `clk`.

Top module: `ref_failover_ctrl`

## Requirements
- R1: While `rst_n` is low, `ref0_bad_o`, `ref1_bad_o`, `active_sel_o` and `switch_pulse_o` are all 0.
- R2: A reference that makes no transition while the synchronized feedback clock makes two rising edges gets its bad flag set to 1. This holds whether the reference is stuck high or stuck low.
- R3: A reference that toggles more often than the feedback clock rises is never flagged.
- R4: A bad flag stays 1 after its reference starts toggling again, until the alarm clear is applied.
- R5: Failover works as follows, with `active_sel_o` = 0 meaning input 0 and 1 meaning input 1. When override is off, the alarm clear is inactive, the active input is flagged and the other input is not, the selection moves to the other input on the next clock. Every change of `active_sel_o` comes with `switch_pulse_o` = 1 for exactly that one cycle.
- R6: When both flags are set and neither override nor clear is active, `active_sel_o` does not change.
- R7: With `man_ovr_i` high, `active_sel_o` follows `req_sel_i` (0 selects input 0, 1 selects input 1). No failover takes place, and the bad flags are still set by stuck inputs.
- R8: While `alarm_clr_n_i` is low, both flags are held at 0 and `active_sel_o` is set to `req_sel_i`. This takes precedence over override and failover.
- R9: In automatic mode, with no flag set and no clear active, a change of `req_sel_i` is ignored and `active_sel_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_i | input | 1 | Reference clock, input 0 |
| ref1_i | input | 1 | Reference clock, input 1 |
| fb_clk_i | input | 1 | Feedback clock that sets the stall window |
| req_sel_i | input | 1 | Requested input: 0 = input 0, 1 = input 1 |
| man_ovr_i | input | 1 | High disables automatic failover |
| alarm_clr_n_i | input | 1 | Active-low clear of flags and realignment of the selection |
| ref0_bad_o | output | 1 | Sticky stall flag of input 0 |
| ref1_bad_o | output | 1 | Sticky stall flag of input 1 |
| active_sel_o | output | 1 | Registered active selection: 0 = input 0, 1 = input 1 |
| switch_pulse_o | output | 1 | One-cycle pulse on each change of the active selection |

## Verification
On every cycle the assertions check that flags stay set unless cleared, and that the clear empties them and realigns the selection. They also check that override tracks the request, that a flagged active input with a healthy partner causes a move, that the selection holds with both inputs flagged or none, and that the pulse coincides exactly with a selection change. Stall detection itself depends on how long an input has been quiet relative to the feedback edges. The bench's scenarios show it: stuck-high and stuck-low inputs, toggling inputs that must never be flagged, a recovering input whose flag must persist, and the simultaneous loss of both references. Its cycle-accurate model compares every output on every clock, which also pins down the synchronizer latency.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
  localparam int NUM_REF   = 2;
  localparam int SIG_REF0  = 0;
  localparam int SIG_REF1  = 1;
  localparam int SIG_FB    = 2;
  localparam int SIG_REQ   = 3;
  localparam int SIG_OVR   = 4;
  localparam int SIG_CLRN  = 5;
  localparam int SIG_COUNT = 6;
  typedef logic [NUM_REF-1:0] ref_vec_t;
endpackage

// File: rtl/rfo_sync.sv
module rfo_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rfo_stall_mon.sv
module rfo_stall_mon #(
  parameter int FAIL_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s_i,
  input  logic fb_rise_i,
  input  logic clr_i,
  output logic bad_o
);
  localparam int CNT_W = $clog2(FAIL_EDGES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_EDGES);

  logic             ref_q;
  logic             ref_edge;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_q, bad_d;

  assign ref_edge = ref_s_i ^ ref_q;

  // next state: quiet counter measured in feedback rising edges
  always_comb begin
    cnt_d = cnt_q;
    bad_d = bad_q;
    if (clr_i) begin
      cnt_d = '0;
      bad_d = 1'b0;
    end else begin
      if (ref_edge) begin
        cnt_d = '0;
      end else if (fb_rise_i && (cnt_q != LIMIT)) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      if (cnt_d == LIMIT) bad_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      ref_q <= ref_s_i;
      cnt_q <= cnt_d;
      bad_q <= bad_d;
    end
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/rfo_sel_ctrl.sv
module rfo_sel_ctrl
  import rfo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ref_vec_t bad_i,
  input  logic     req_i,
  input  logic     ovr_i,
  input  logic     clr_i,
  output logic     sel_o,
  output logic     pulse_o
);
  logic sel_q, sel_d;
  logic pulse_q, pulse_d;
  logic cur_bad, alt_bad;

  assign cur_bad = bad_i[sel_q];
  assign alt_bad = bad_i[~sel_q];

  // priority: clear, then override, then automatic failover
  always_comb begin
    sel_d = sel_q;
    if (clr_i || ovr_i) begin
      sel_d = req_i;
    end else if (cur_bad && !alt_bad) begin
      sel_d = ~sel_q;
    end
    pulse_d = sel_d ^ sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      pulse_q <= pulse_d;
    end
  end

  assign sel_o   = sel_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/ref_failover_ctrl.sv
module ref_failover_ctrl
  import rfo_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAIL_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref0_i,
  input  logic ref1_i,
  input  logic fb_clk_i,
  input  logic req_sel_i,
  input  logic man_ovr_i,
  input  logic alarm_clr_n_i,
  output logic ref0_bad_o,
  output logic ref1_bad_o,
  output logic active_sel_o,
  output logic switch_pulse_o
);
  logic [SIG_COUNT-1:0] raw, syn;
  logic     fb_q, fb_rise;
  logic     req_s, ovr_s, clr_act;
  ref_vec_t ref_s, bad;

  assign raw[SIG_REF0] = ref0_i;
  assign raw[SIG_REF1] = ref1_i;
  assign raw[SIG_FB]   = fb_clk_i;
  assign raw[SIG_REQ]  = req_sel_i;
  assign raw[SIG_OVR]  = man_ovr_i;
  assign raw[SIG_CLRN] = alarm_clr_n_i;

  rfo_sync #(.W(SIG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ref_s   = {syn[SIG_REF1], syn[SIG_REF0]};
  assign req_s   = syn[SIG_REQ];
  assign ovr_s   = syn[SIG_OVR];
  assign clr_act = ~syn[SIG_CLRN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= syn[SIG_FB];
  end

  assign fb_rise = syn[SIG_FB] & ~fb_q;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
    rfo_stall_mon #(.FAIL_EDGES(FAIL_EDGES)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_s_i   (ref_s[g]),
      .fb_rise_i (fb_rise),
      .clr_i     (clr_act),
      .bad_o     (bad[g])
    );
  end

  rfo_sel_ctrl u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .bad_i   (bad),
    .req_i   (req_s),
    .ovr_i   (ovr_s),
    .clr_i   (clr_act),
    .sel_o   (active_sel_o),
    .pulse_o (switch_pulse_o)
  );

  assign ref0_bad_o = bad[0];
  assign ref1_bad_o = bad[1];
endmodule

// File: rtl/rfo_checker.sv
module rfo_checker (
  input logic clk,
  input logic rst_n,
  input logic ref0_bad,
  input logic ref1_bad,
  input logic active_sel,
  input logic switch_pulse,
  input logic req_s,
  input logic ovr_s,
  input logic clr_act
);
  // R4
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref0_bad && !clr_act) |=> ref0_bad);
  // R4
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref1_bad && !clr_act) |=> ref1_bad);
  // R5
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (active_sel != $past(active_sel)));
  // R5
  change_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_pulse |-> $stable(active_sel));
  // R5
  failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ovr_s && !active_sel && ref0_bad && !ref1_bad) |=> active_sel);
  // R6
  both_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ovr_s && ref0_bad && ref1_bad) |=> $stable(active_sel));
  // R7
  override_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_s && !clr_act) |=> (active_sel == $past(req_s)));
  // R8
  clear_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (!ref0_bad && !ref1_bad && (active_sel == $past(req_s))));
  // R9
  auto_ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ovr_s && !ref0_bad && !ref1_bad) |=> $stable(active_sel));
endmodule

bind ref_failover_ctrl rfo_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref0_bad     (ref0_bad_o),
  .ref1_bad     (ref1_bad_o),
  .active_sel   (active_sel_o),
  .switch_pulse (switch_pulse_o),
  .req_s        (req_s),
  .ovr_s        (ovr_s),
  .clr_act      (clr_act)
);

// File: tb/sim_ref_failover_ctrl.sv
module sim_ref_failover_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref0, ref1, fb, req, ovr, clrn;
  logic bad0_o, bad1_o, sel_o, pulse_o;

  ref_failover_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .ref0_i (ref0), .ref1_i (ref1),
    .fb_clk_i (fb), .req_sel_i (req), .man_ovr_i (ovr),
    .alarm_clr_n_i (clrn), .ref0_bad_o (bad0_o), .ref1_bad_o (bad1_o),
    .active_sel_o (sel_o), .switch_pulse_o (pulse_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, pulses = 0;
  string phase = "R1";
  logic run0 = 1'b0, run1 = 1'b0;
  bit done = 1'b0;

  // behavioural reference model: inputs seen three edges late
  logic [5:0] hist[$];
  int   m_cnt[2];
  logic m_bad[2];
  logic m_sel, m_pulse;
  logic [5:0] r, rp;
  int   nc;
  logic nb[2];
  logic seln, mclr;

  function automatic logic [5:0] hget(int k);
    return (k < hist.size()) ? hist[k] : 6'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_cnt[0] = 0; m_cnt[1] = 0;
      m_bad[0] = 1'b0; m_bad[1] = 1'b0;
      m_sel = 1'b0; m_pulse = 1'b0;
    end else begin
      hist.push_front({clrn, ovr, req, fb, ref1, ref0});
      if (hist.size() > 4) void'(hist.pop_back());
      r = hget(2); rp = hget(3);
      mclr = !r[5];
      for (int i = 0; i < 2; i++) begin
        if (mclr || (r[i] != rp[i])) nc = 0;
        else if (r[2] && !rp[2] && m_cnt[i] < 2) nc = m_cnt[i] + 1;
        else nc = m_cnt[i];
        nb[i] = mclr ? 1'b0 : (m_bad[i] || nc == 2);
        m_cnt[i] = nc;
      end
      if (mclr || r[4]) seln = r[3];
      else if (m_bad[int'(m_sel)] && !m_bad[int'(!m_sel)]) seln = !m_sel;
      else seln = m_sel;
      m_pulse = (seln != m_sel);
      m_sel = seln;
      m_bad[0] = nb[0]; m_bad[1] = nb[1];
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      chk({phase, " model ref0_bad"}, bad0_o, m_bad[0]);
      chk({phase, " model ref1_bad"}, bad1_o, m_bad[1]);
      chk({phase, " model active_sel"}, sel_o, m_sel);
      chk({phase, " model switch_pulse"}, pulse_o, m_pulse);
      if (pulse_o) pulses++;
      cyc++;
      if (cyc % 8 == 0) fb = ~fb;
      if (run0 && cyc % 3 == 0) ref0 = ~ref0;
      if (run1 && cyc % 5 == 0) ref1 = ~ref1;
    end
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; ref0 = 0; ref1 = 0; fb = 0; req = 0; ovr = 0; clrn = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ref0_bad", bad0_o, 1'b0);
    chk("R1 ref1_bad", bad1_o, 1'b0);
    chk("R1 active_sel", sel_o, 1'b0);
    chk("R1 switch_pulse", pulse_o, 1'b0);
    rst_n = 1'b1;

    // R3: both toggling, never flagged
    phase = "R3"; run0 = 1; run1 = 1;
    run(120);
    chk("R3 ref0_bad", bad0_o, 1'b0);
    chk("R3 ref1_bad", bad1_o, 1'b0);

    // R9: request change ignored in automatic mode
    phase = "R9"; req = 1;
    run(40);
    chk("R9 active_sel held", sel_o, 1'b0);

    // R2 / R5: input 0 stuck high, failover to input 1
    phase = "R2"; pulses = 0; run0 = 0; ref0 = 1;
    run(60);
    chk("R2 ref0_bad stuck high", bad0_o, 1'b1);
    chk("R2 ref1_bad", bad1_o, 1'b0);
    chk("R5 active_sel after failover", sel_o, 1'b1);
    chk_int("R5 switch pulses", pulses, 1);

    // R4: input 0 recovers, flag persists
    phase = "R4"; run0 = 1;
    run(60);
    chk("R4 ref0_bad sticky", bad0_o, 1'b1);
    chk("R4 active_sel", sel_o, 1'b1);

    // R8: clear realigns to request 0
    phase = "R8"; req = 0; clrn = 0;
    run(4);
    clrn = 1;
    run(8);
    chk("R8 ref0_bad cleared", bad0_o, 1'b0);
    chk("R8 ref1_bad cleared", bad1_o, 1'b0);
    chk("R8 active_sel realigned", sel_o, 1'b0);

    // R6: both stuck low at the same time, selection holds
    phase = "R6"; run0 = 0; run1 = 0; ref0 = 1; ref1 = 1;
    run(1);
    ref0 = 0; ref1 = 0; pulses = 0;
    run(80);
    chk("R6 ref0_bad stuck low", bad0_o, 1'b1);
    chk("R6 ref1_bad stuck low", bad1_o, 1'b1);
    chk("R6 active_sel held", sel_o, 1'b0);
    chk_int("R6 switch pulses", pulses, 0);

    // R7: override follows request, flags still report
    phase = "R7"; ovr = 1; req = 1;
    run(6);
    chk("R7 active_sel follows 1", sel_o, 1'b1);
    chk("R7 ref0_bad still set", bad0_o, 1'b1);
    req = 0;
    run(6);
    chk("R7 active_sel follows 0", sel_o, 1'b0);
    clrn = 0;
    run(4);
    clrn = 1; run0 = 1; run1 = 1;
    run(40);
    run0 = 0;
    run(60);
    chk("R7 ref0_bad set under override", bad0_o, 1'b1);
    chk("R7 no failover under override", sel_o, 1'b0);

    // R5: override released, automatic failover takes place
    phase = "R5"; ovr = 0;
    run(10);
    chk("R5 failover after override release", sel_o, 1'b1);
    chk("R5 ref1_bad", bad1_o, 1'b0);

    wrap_up();
  end
endmodule